// File: doc/BRIEF.md
# Transmit Cell Framer and Nibble Scrambler

This block sits on the transmit side of a 25.6 Mbps cell line. It takes 53-byte cells one byte at a time over a valid/ready handshake. It breaks each byte into two nibbles, high nibble first, and scrambles them with a 10-bit pseudo-random nibble generator. It produces one tagged nibble per clock for a downstream symbol encoder. Each nibble is tagged as idle, scrambled data, an escape, or a plain command code. Cell boundaries come from a count of accepted bytes, so no framing input is needed.

Every cell is preceded by a two-nibble start-of-cell command. That command is either escape-escape, which also reloads the generator, or escape followed by code 4. The generator advances on every nibble the block emits, commands included. The reloading form is chosen only when the generator has gone through its whole 1023-step period since the last reload. It is also chosen for the first cell after reset. A one-cycle marker strobe asks for an escape-then-code-8 timing marker. The marker is sent at the next gap between cells, ahead of any start-of-cell command.

Top module: `nibble_scrambler_tx`

## Requirements
- R1: While reset is held and in the first cycle after it, outTag is 0 (idle) and inReady is low.
- R2: Each accepted byte leaves as two data-tagged (tag 1) nibbles, bits 7:4 first. Each nibble equals the plain nibble XOR the generator mask. With generator bit sequence x[n] = x[n-7] ^ x[n-10], the mask bits 3..0 are x[t-3], x[t-2], x[t-1], x[t]. Each emitted nibble moves t forward by 4.
- R3: The generator moves forward by one nibble step for every emitted non-idle nibble, escapes and codes included.
- R4: Every cell is one escape (tag 2, nibble 0) and a second command nibble, followed by exactly 106 data nibbles. A cell starts only when inValid is high in a gap, and inReady is high only while a data byte is awaited inside a cell.
- R5: The second start-of-cell nibble is a second escape when at least 1023 nibbles have been emitted since the last reload, and after reset. Otherwise it is code 4 (tag 3, nibble 4).
- R6: On the escape-escape command the generator reloads to all ones, so the first data nibble of that cell is XORed with 1111b. The nibble-count toward R5 restarts at zero.
- R7: A markReq pulse makes the block send escape then code 8 (tag 3, nibble 8) exactly once. It is sent in the next gap between cells, before that gap's start-of-cell. It is never sent inside a cell.
- R8: When inValid is low while a data byte is awaited, the block emits idle and the generator does not move.
- R9: Command codes leave without scrambling, and only the values 4 and 8 occur. A code nibble always follows an escape.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Byte offered |
| inData | input | 8 | Cell byte |
| inReady | output | 1 | Byte taken this cycle when inValid is high |
| markReq | input | 1 | One-cycle timing-marker request |
| outTag | output | 2 | 0 idle, 1 data, 2 escape, 3 command code |
| outNibble | output | 4 | Nibble value, registered |

## Verification
The bench streams random bytes with random valid gaps, so the cells vary between back-to-back and widely spaced. Its own generator model checks every data nibble, and a mismatch shows whether command nibbles advanced the generator. The run is long enough to cross the 1023-step period several times, which separates the escape-escape start from the code-4 start and checks the reload mask. Directed cases cover a marker with no traffic, a marker raised mid-cell that must wait for the boundary, and a long mid-cell stall that must leave the scrambling sequence unchanged.

// File: rtl/nsc_pkg.sv
package nsc_pkg;

  typedef enum logic [1:0] {
    TAG_IDLE = 2'd0,
    TAG_DATA = 2'd1,
    TAG_ESC  = 2'd2,
    TAG_CODE = 2'd3
  } nibTag_t;

  typedef enum logic [2:0] {
    SEL_IDLE,
    SEL_HI,
    SEL_LO,
    SEL_ESC,
    SEL_MARK,
    SEL_SOC
  } nibSel_t;

  typedef struct packed {
    nibSel_t sel;
    logic    reload;
  } ctrlStrobe_t;

  localparam int NIB_W = 4;
  localparam logic [NIB_W-1:0] CODE_SOC  = 4'h4;
  localparam logic [NIB_W-1:0] CODE_MARK = 4'h8;
  localparam logic [NIB_W-1:0] ESC_VALUE = 4'h0;

endpackage

// File: rtl/nsc_ctrl.sv
module nsc_ctrl
  import nsc_pkg::*;
#(
  parameter int CELL_BYTES = 53
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        markReq,
  input  logic        periodDone,
  output logic        inReady,
  output ctrlStrobe_t strobe
);

  localparam int CNT_W = $clog2(CELL_BYTES);
  localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(CELL_BYTES - 1);

  typedef enum logic [2:0] {ST_GAP, ST_MCODE, ST_SOC2, ST_HI, ST_LO} ctrlState_t;

  ctrlState_t state, nextState;
  logic [CNT_W-1:0] byteCnt;
  logic markPend, clrMark, socReset, latchReset;

  always_comb begin
    strobe     = '{sel: SEL_IDLE, reload: 1'b0};
    nextState  = state;
    clrMark    = 1'b0;
    latchReset = 1'b0;
    inReady    = (state == ST_HI);
    case (state)
      ST_GAP: begin
        if (markPend) begin
          strobe.sel = SEL_ESC;
          nextState  = ST_MCODE;
        end else if (inValid) begin
          strobe.sel = SEL_ESC;
          latchReset = 1'b1;
          nextState  = ST_SOC2;
        end
      end
      ST_MCODE: begin
        strobe.sel = SEL_MARK;
        clrMark    = 1'b1;
        nextState  = ST_GAP;
      end
      ST_SOC2: begin
        if (socReset) begin
          strobe.sel    = SEL_ESC;
          strobe.reload = 1'b1;
        end else begin
          strobe.sel = SEL_SOC;
        end
        nextState = ST_HI;
      end
      ST_HI: begin
        if (inValid) begin
          strobe.sel = SEL_HI;
          nextState  = ST_LO;
        end
      end
      ST_LO: begin
        strobe.sel = SEL_LO;
        nextState  = (byteCnt == LAST_BYTE) ? ST_GAP : ST_HI;
      end
      default: nextState = ST_GAP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_GAP;
      byteCnt  <= '0;
      markPend <= 1'b0;
      socReset <= 1'b0;
    end else begin
      state    <= nextState;
      markPend <= (markPend & ~clrMark) | markReq;
      if (latchReset) socReset <= periodDone;
      if (state == ST_SOC2) byteCnt <= '0;
      else if (state == ST_LO) byteCnt <= byteCnt + 1'b1;
    end
  end

endmodule

// File: rtl/nsc_datapath.sv
module nsc_datapath
  import nsc_pkg::*;
#(
  parameter int PRNG_W  = 10,
  parameter int TAP_EXP = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [2*NIB_W-1:0] inData,
  output logic [1:0]        outTag,
  output logic [NIB_W-1:0]  outNibble,
  output logic              periodDone,
  output logic [PRNG_W-1:0] prngState
);

  localparam logic [PRNG_W-1:0] PERIOD  = PRNG_W'((1 << PRNG_W) - 1);
  localparam logic [PRNG_W-1:0] ALL_ONE = '1;
  localparam int TAP_IDX = TAP_EXP - 1;

  logic [PRNG_W-1:0] prng, stepCnt, prngNext;
  logic [NIB_W-1:0]  loNib, mask, nibComb;
  nibTag_t           tagComb;
  logic              emit;

  // Each generator bit feeds one stage of a nibble-wide advance.
  logic [PRNG_W-1:0] stage [NIB_W+1];
  assign stage[0] = prng;
  for (genvar g = 0; g < NIB_W; g++) begin : g_step
    assign stage[g+1] = {stage[g][PRNG_W-2:0], stage[g][PRNG_W-1] ^ stage[g][TAP_IDX]};
  end
  assign prngNext = stage[NIB_W];

  assign mask       = prng[NIB_W-1:0];
  assign emit       = (strobe.sel != SEL_IDLE);
  assign periodDone = (stepCnt == PERIOD);
  assign prngState  = prng;

  always_comb begin
    tagComb = TAG_IDLE;
    nibComb = '0;
    case (strobe.sel)
      SEL_HI:   begin tagComb = TAG_DATA; nibComb = inData[2*NIB_W-1:NIB_W] ^ mask; end
      SEL_LO:   begin tagComb = TAG_DATA; nibComb = loNib ^ mask; end
      SEL_ESC:  begin tagComb = TAG_ESC;  nibComb = ESC_VALUE; end
      SEL_MARK: begin tagComb = TAG_CODE; nibComb = CODE_MARK; end
      SEL_SOC:  begin tagComb = TAG_CODE; nibComb = CODE_SOC; end
      default:  begin tagComb = TAG_IDLE; nibComb = '0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prng      <= ALL_ONE;
      stepCnt   <= PERIOD;
      loNib     <= '0;
      outTag    <= TAG_IDLE;
      outNibble <= '0;
    end else begin
      outTag    <= tagComb;
      outNibble <= nibComb;
      if (strobe.sel == SEL_HI) loNib <= inData[NIB_W-1:0];
      if (strobe.reload) begin
        prng    <= ALL_ONE;
        stepCnt <= '0;
      end else if (emit) begin
        prng <= prngNext;
        if (!periodDone) stepCnt <= stepCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/nibble_scrambler_tx.sv
module nibble_scrambler_tx
  import nsc_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  parameter int PRNG_W     = 10,
  parameter int TAP_EXP    = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [7:0] inData,
  output logic       inReady,
  input  logic       markReq,
  output logic [1:0] outTag,
  output logic [3:0] outNibble
);

  ctrlStrobe_t       strobe;
  logic              periodDone;
  logic [PRNG_W-1:0] prngState;

  nsc_ctrl #(.CELL_BYTES(CELL_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .markReq(markReq),
    .periodDone(periodDone), .inReady(inReady), .strobe(strobe)
  );

  nsc_datapath #(.PRNG_W(PRNG_W), .TAP_EXP(TAP_EXP)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData),
    .outTag(outTag), .outNibble(outNibble), .periodDone(periodDone),
    .prngState(prngState)
  );

endmodule

// File: rtl/nsc_checker.sv
module nsc_checker #(
  parameter int PRNG_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic [1:0]        outTag,
  input logic [3:0]        outNibble,
  input logic [PRNG_W-1:0] prngState
);

  p_accept_hi_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (outTag == 2'd1));

  p_accept_lo_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> ##1 (outTag == 2'd1));

  p_stall_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && !inValid) |=> (outTag == 2'd0));

  p_idle_holds_prng_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outTag == 2'd0) |-> $stable(prngState));

  p_reload_on_xx_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outTag == 2'd2 && $past(outTag) == 2'd2) |-> (prngState == '1));

  p_code_after_esc_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outTag == 2'd3) |-> ($past(outTag) == 2'd2 && (outNibble == 4'h4 || outNibble == 4'h8)));

endmodule

bind nibble_scrambler_tx nsc_checker #(.PRNG_W(PRNG_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .outTag(outTag), .outNibble(outNibble), .prngState(prngState)
);

// File: tb/nibble_scrambler_tx_bench.sv
module nibble_scrambler_tx_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [7:0] inData = '0;
  logic inReady;
  logic markReq = 1'b0;
  logic [1:0] outTag;
  logic [3:0] outNibble;

  always #4 clk = ~clk;

  nibble_scrambler_tx u_nibble_scrambler_tx (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inReady(inReady),
    .markReq(markReq), .outTag(outTag), .outNibble(outNibble)
  );

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference generator: s[k] holds x[t-k]
  logic [9:0] mS = 10'h3FF;
  int mCnt = 1023;

  function automatic logic [9:0] refAdvance(input logic [9:0] s);
    logic [9:0] r = s;
    for (int i = 0; i < 4; i++) r = {r[8:0], r[9] ^ r[6]};
    return r;
  endfunction

  task automatic modelStep();
    mS = refAdvance(mS);
    if (mCnt < 1023) mCnt++;
  endtask

  typedef enum {P_GAP, P_AFTER_ESC, P_CELL} pState_t;
  pState_t pState = P_GAP;
  int dataLeft = 0;
  bit hiNext = 1;
  bit xxExp = 0;
  int xxCount = 0, cellCount = 0, served = 0;
  bit outstanding = 0, stampInCell = 0;
  logic [7:0] accQ[$];

  task automatic parseOut(input logic [1:0] tag, input logic [3:0] nib);
    logic [3:0] plain;
    case (pState)
      P_GAP: begin
        if (tag == 2'd2) begin
          check(nib == 4'h0, "R4 escape value", nib, 0);
          xxExp = (mCnt == 1023);
          modelStep();
          pState = P_AFTER_ESC;
        end else if (tag != 2'd0) begin
          check(0, "R4 non-idle outside command", tag, 0);
        end
      end
      P_AFTER_ESC: begin
        if (tag == 2'd2) begin
          check(xxExp, "R5 reset start chosen", 1, xxExp);
          check(!(outstanding && stampInCell), "R7 marker before start", 0, 1);
          xxCount++; cellCount++;
          mS = 10'h3FF; mCnt = 0;
          pState = P_CELL; dataLeft = 106; hiNext = 1;
        end else if (tag == 2'd3 && nib == 4'h8) begin
          check(outstanding, "R7 marker only on request", 0, 1);
          outstanding = 0; served++;
          modelStep();
          pState = P_GAP;
        end else if (tag == 2'd3 && nib == 4'h4) begin
          check(!xxExp, "R5 plain start chosen", 4, 2);
          check(!(outstanding && stampInCell), "R7 marker before start", 4, 8);
          cellCount++;
          modelStep();
          pState = P_CELL; dataLeft = 106; hiNext = 1;
        end else begin
          check(0, "R9 bad command after escape", {tag, nib}, 0);
          pState = P_GAP;
        end
      end
      P_CELL: begin
        if (tag == 2'd1) begin
          if (accQ.size() == 0) begin
            check(0, "R4 data without accepted byte", nib, 0);
          end else begin
            plain = hiNext ? accQ[0][7:4] : accQ[0][3:0];
            if (!hiNext) void'(accQ.pop_front());
            check(nib == (plain ^ mS[3:0]), "R2/R3/R6/R8 scrambled data", nib, plain ^ mS[3:0]);
          end
          hiNext = !hiNext;
          modelStep();
          dataLeft--;
          if (dataLeft == 0) pState = P_GAP;
        end else if (tag != 2'd0) begin
          check(0, "R4 command inside cell", tag, 1);
        end
      end
      default: pState = P_GAP;
    endcase
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    bit hsPrev = 0;
    int validPct;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check(outTag == 2'd0, "R1 idle tag in reset", outTag, 0);
    check(inReady == 1'b0, "R1 ready low in reset", inReady, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outTag == 2'd0, "R1 idle tag after reset", outTag, 0);
    check(inReady == 1'b0, "R1 ready low after reset", inReady, 0);

    for (int cyc = 0; cyc < 8000; cyc++) begin
      @(negedge clk);
      if (hsPrev) accQ.push_back(inData);
      parseOut(outTag, outNibble);

      if (cyc == 30) check(served == 1, "R7 marker with no traffic", served, 1);
      if (cyc == 639) check(outTag == 2'd0, "R8 idle during stall", outTag, 0);

      validPct = (cyc < 40 || (cyc >= 600 && cyc < 640)) ? 0 : 85;
      if (validPct == 0) begin
        inValid = 1'b0;
      end else if (!inValid || hsPrev) begin
        inValid = (($urandom % 100) < validPct);
        inData  = 8'($urandom);
      end

      markReq = 1'b0;
      if (!outstanding && (cyc == 5 || cyc == 300 || (cyc < 7000 && ($urandom % 150) == 0))) begin
        markReq = 1'b1;
        outstanding = 1;
        stampInCell = (pState == P_CELL && dataLeft > 4);
      end

      #1 hsPrev = inValid && inReady;
    end

    check(!outstanding, "R7 every marker sent", outstanding, 0);
    check(xxCount >= 3, "R5 periodic reset starts", xxCount, 3);
    check(cellCount >= 30, "R4 cells framed", cellCount, 30);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule